// File: doc/BRIEF.md
# Framing Error Injector and Monitor

This block sits between the parallel side of a framed serializer and the serial line. Each word-clock cycle it takes one payload word, wraps it in a start bit and a stop bit, and passes the framed symbol on. At a programmed period it damages one symbol by putting its start bit or its stop bit at the wrong level. An error flag marks the damaged symbol in the same cycle that the symbol leaves the block.

It also watches the receiver's active-low lock signal and times two intervals in word-clock cycles. The first runs from the error flag to the point where the receiver reports loss of lock. Values above a limit of 5 cycles are flagged as a violation. The second runs from loss of lock until lock returns. The block keeps the last and the largest value of that second interval. While the receiver is out of lock, the block asks the transmitter for sync patterns.

This is used in a bench setup to measure how quickly a receiver notices framing damage and how long it takes to lock again.

Top module: `frame_fault_injmon`

## Requirements
- R1: While reset is applied, `sym_o` shows the idle frame (bit 0 = 1, top bit = 0, payload 0), and every other output is 0.
- R2: A symbol that is not damaged appears on `sym_o` one clock after its payload is sampled, with payload in bits PAY_W:1, start bit (bit 0) at 1 and stop bit (top bit) at 0.
- R3: With `period_i` = P > 0, the P-th symbol since reset is damaged, and after that every P-th symbol. The default used is 200.
- R4: When `period_i` is 0, no symbol is damaged and `err_o` stays low.
- R5: A damaged symbol has exactly one framing bit inverted: start bit forced to 0 or stop bit forced to 1. The first damage after reset hits the start bit, and after that the two alternate.
- R6: `err_o` is high in exactly the cycles in which `sym_o` carries a damaged symbol.
- R7: `lat_last_o` holds the number of clock edges from the edge that samples `err_o` high while `lock_n_i` is low, up to the first later edge that samples `lock_n_i` high. The count saturates at all ones.
- R8: `lat_viol_o` is 1 when the latest captured `lat_last_o` exceeds 5, and 0 otherwise.
- R9: `rec_last_o` holds the number of clock edges during which `lock_n_i` was sampled high in the latest out-of-lock episode. It updates on the first edge that samples `lock_n_i` low again. `rec_max_o` holds the largest such value since reset.
- R10: The recovery count saturates at all ones (65535 for the default width).
- R11: `sync_req_o` equals the value of `lock_n_i` sampled at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| payload_i | input | PAY_W | Payload word from the serializer side |
| period_i | input | PER_W | Damage period in symbols, 0 = off |
| lock_n_i | input | 1 | Receiver lock, low = locked |
| sym_o | output | PAY_W+2 | Framed symbol to the line |
| err_o | output | 1 | Marks a damaged symbol |
| sync_req_o | output | 1 | Sync pattern request to the transmitter |
| lat_last_o | output | LAT_W | Last error-to-loss-of-lock interval |
| lat_viol_o | output | 1 | Last interval exceeded the limit |
| rec_last_o | output | REC_W | Last recovery interval |
| rec_max_o | output | REC_W | Largest recovery interval |

## Verification
If the period counter slips, `err_o` appears one or more cycles away from the expected symbol on the first damage. This shows up within one period. If the bit-select toggle is wrong, the wrong framing bit is inverted on the first or second damaged symbol. If the interval counters start or stop on the wrong edge, the reported values are off by one. That error is visible one cycle after each episode ends. A per-cycle reference model compares every output, so each of these faults is caught at the first cycle where it appears. Directed episodes with known delays also pin the exact counts and the saturation points.

// File: rtl/ffim_pkg.sv
package ffim_pkg;
  typedef enum logic {
    HIT_START = 1'b0,
    HIT_STOP  = 1'b1
  } hit_e;
endpackage

// File: rtl/ffim_rst_sync.sv
module ffim_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ffim_inject.sv
module ffim_inject
  import ffim_pkg::*;
#(
  parameter int PAY_W = 18,
  parameter int PER_W = 16,
  localparam int SYM_W = PAY_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PAY_W-1:0] payload_i,
  input  logic [PER_W-1:0] period_i,
  output logic [SYM_W-1:0] sym_o,
  output logic             err_o
);
  logic [PER_W-1:0] cnt_q, cnt_d;
  hit_e             sel_q, sel_d;
  logic [SYM_W-1:0] sym_d;
  logic             hit;

  always_comb begin
    hit   = (period_i != '0) && (cnt_q >= period_i - 1'b1);
    cnt_d = cnt_q;
    sel_d = sel_q;
    sym_d = {1'b0, payload_i, 1'b1};
    if (period_i == '0) begin
      cnt_d = '0;
    end else if (hit) begin
      cnt_d = '0;
      sel_d = (sel_q == HIT_START) ? HIT_STOP : HIT_START;
      if (sel_q == HIT_START) sym_d[0] = 1'b0;
      else                    sym_d[SYM_W-1] = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= HIT_START;
      sym_o <= {{(SYM_W-1){1'b0}}, 1'b1};
      err_o <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sel_q <= sel_d;
      sym_o <= sym_d;
      err_o <= hit;
    end
  end
endmodule

// File: rtl/ffim_lat_meas.sv
module ffim_lat_meas #(
  parameter int LAT_W   = 8,
  parameter int LAT_MAX = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_i,
  input  logic             lock_n_i,
  output logic [LAT_W-1:0] lat_last_o,
  output logic             lat_viol_o
);
  logic             run_q, run_d;
  logic [LAT_W-1:0] cnt_q, cnt_d, cnt_inc, last_d;
  logic             viol_d;

  always_comb begin
    cnt_inc = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
    run_d   = run_q;
    cnt_d   = cnt_q;
    last_d  = lat_last_o;
    viol_d  = lat_viol_o;
    if (run_q && lock_n_i) begin
      run_d  = 1'b0;
      last_d = cnt_inc;
      viol_d = (cnt_inc > LAT_W'(LAT_MAX));
    end else if (err_i && !lock_n_i) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (run_q) begin
      cnt_d = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      cnt_q      <= '0;
      lat_last_o <= '0;
      lat_viol_o <= 1'b0;
    end else begin
      run_q      <= run_d;
      cnt_q      <= cnt_d;
      lat_last_o <= last_d;
      lat_viol_o <= viol_d;
    end
  end
endmodule

// File: rtl/ffim_rec_meas.sv
module ffim_rec_meas #(
  parameter int REC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_n_i,
  output logic             out_o,
  output logic [REC_W-1:0] rec_last_o,
  output logic [REC_W-1:0] rec_max_o
);
  logic [REC_W-1:0] cnt_q, cnt_d, last_d, max_d;
  logic             out_d;

  always_comb begin
    cnt_d  = cnt_q;
    out_d  = out_o;
    last_d = rec_last_o;
    max_d  = rec_max_o;
    if (lock_n_i) begin
      cnt_d = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
      out_d = 1'b1;
    end else if (out_o) begin
      last_d = cnt_q;
      max_d  = (cnt_q > rec_max_o) ? cnt_q : rec_max_o;
      cnt_d  = '0;
      out_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      out_o      <= 1'b0;
      rec_last_o <= '0;
      rec_max_o  <= '0;
    end else begin
      cnt_q      <= cnt_d;
      out_o      <= out_d;
      rec_last_o <= last_d;
      rec_max_o  <= max_d;
    end
  end
endmodule

// File: rtl/frame_fault_injmon.sv
module frame_fault_injmon #(
  parameter int PAY_W   = 18,
  parameter int PER_W   = 16,
  parameter int LAT_W   = 8,
  parameter int LAT_MAX = 5,
  parameter int REC_W   = 16,
  localparam int SYM_W  = PAY_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PAY_W-1:0] payload_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             lock_n_i,
  output logic [SYM_W-1:0] sym_o,
  output logic             err_o,
  output logic             sync_req_o,
  output logic [LAT_W-1:0] lat_last_o,
  output logic             lat_viol_o,
  output logic [REC_W-1:0] rec_last_o,
  output logic [REC_W-1:0] rec_max_o
);
  logic rst_sync_n;

  ffim_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ffim_inject #(.PAY_W(PAY_W), .PER_W(PER_W)) u_inj (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .payload_i (payload_i),
    .period_i  (period_i),
    .sym_o     (sym_o),
    .err_o     (err_o)
  );

  ffim_lat_meas #(.LAT_W(LAT_W), .LAT_MAX(LAT_MAX)) u_lat (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .err_i      (err_o),
    .lock_n_i   (lock_n_i),
    .lat_last_o (lat_last_o),
    .lat_viol_o (lat_viol_o)
  );

  ffim_rec_meas #(.REC_W(REC_W)) u_rec (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .lock_n_i   (lock_n_i),
    .out_o      (sync_req_o),
    .rec_last_o (rec_last_o),
    .rec_max_o  (rec_max_o)
  );
endmodule

// File: rtl/ffim_checker.sv
module ffim_checker #(
  parameter int SYM_W   = 20,
  parameter int LAT_W   = 8,
  parameter int LAT_MAX = 5,
  parameter int REC_W   = 16,
  parameter int PER_W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PER_W-1:0] period_i,
  input logic             lock_n_i,
  input logic [SYM_W-1:0] sym_o,
  input logic             err_o,
  input logic             sync_req_o,
  input logic [LAT_W-1:0] lat_last_o,
  input logic             lat_viol_o,
  input logic [REC_W-1:0] rec_last_o,
  input logic [REC_W-1:0] rec_max_o
);
  assert_flag_marks_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!sym_o[0] || sym_o[SYM_W-1]));

  assert_clean_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !err_o |-> (sym_o[0] && !sym_o[SYM_W-1]));

  assert_one_bit_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !(!sym_o[0] && sym_o[SYM_W-1]));

  assert_sync_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lock_n_i |=> sync_req_o);

  assert_sync_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_n_i |=> !sync_req_o);

  assert_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (period_i == '0) |=> !err_o);

  assert_max_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rec_max_o >= rec_last_o);

  assert_viol_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat_viol_o) |-> (lat_last_o > LAT_W'(LAT_MAX)));
endmodule

bind frame_fault_injmon ffim_checker #(
  .SYM_W(SYM_W), .LAT_W(LAT_W), .LAT_MAX(LAT_MAX), .REC_W(REC_W), .PER_W(PER_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .period_i   (period_i),
  .lock_n_i   (lock_n_i),
  .sym_o      (sym_o),
  .err_o      (err_o),
  .sync_req_o (sync_req_o),
  .lat_last_o (lat_last_o),
  .lat_viol_o (lat_viol_o),
  .rec_last_o (rec_last_o),
  .rec_max_o  (rec_max_o)
);

// File: tb/test_frame_fault_injmon.sv
module test_frame_fault_injmon;
  localparam int PW = 18;
  localparam int SW = PW + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] payload = '0;
  logic [15:0]   period = 16'd200;
  logic          lock_n = 1'b0;
  logic [SW-1:0] sym_o;
  logic          err_o, sync_req_o, lat_viol_o;
  logic [7:0]    lat_last_o;
  logic [15:0]   rec_last_o, rec_max_o;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0, cmp_on = 0;

  always #5 clk = ~clk;

  frame_fault_injmon i_frame_fault_injmon (
    .clk(clk), .rst_n(rst_n), .payload_i(payload), .period_i(period),
    .lock_n_i(lock_n), .sym_o(sym_o), .err_o(err_o), .sync_req_o(sync_req_o),
    .lat_last_o(lat_last_o), .lat_viol_o(lat_viol_o),
    .rec_last_o(rec_last_o), .rec_max_o(rec_max_o)
  );

  // reference model state
  logic [1:0]    m_rs = 2'b00;
  int            m_cnt = 0, m_lcnt = 0, m_rcnt = 0;
  bit            m_sel = 0, m_lrun = 0;
  logic [SW-1:0] e_sym = {{(SW-1){1'b0}}, 1'b1};
  bit            e_err = 0, e_viol = 0, e_sync = 0;
  int            e_lat = 0, e_rlast = 0, e_rmax = 0;

  function automatic int sat(int v, int lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  function automatic logic [SW-1:0] frame(logic [PW-1:0] p, bit hit, bit sel);
    logic [SW-1:0] s;
    s = {1'b0, p, 1'b1};
    if (hit) begin
      if (!sel) s[0] = 1'b0;
      else      s[SW-1] = 1'b1;
    end
    return s;
  endfunction

  always @(posedge clk) begin
    bit active, hit;
    if (!rst_n) begin
      m_rs = 2'b00;
    end else begin
      active = m_rs[1];
      m_rs = {m_rs[0], 1'b1};
      if (active) begin
        // latency (uses flag value before this edge)
        if (m_lrun && lock_n) begin
          m_lrun = 0; e_lat = sat(m_lcnt, 255); e_viol = (e_lat > 5);
        end else if (e_err && !lock_n) begin
          m_lrun = 1; m_lcnt = 0;
        end else if (m_lrun) begin
          m_lcnt = sat(m_lcnt, 255);
        end
        // recovery
        if (lock_n) begin
          m_rcnt = sat(m_rcnt, 65535); e_sync = 1;
        end else if (e_sync) begin
          e_rlast = m_rcnt; if (m_rcnt > e_rmax) e_rmax = m_rcnt;
          m_rcnt = 0; e_sync = 0;
        end
        // injection
        hit = (period != 0) && (m_cnt >= int'(period) - 1);
        e_sym = frame(payload, hit, m_sel);
        e_err = hit;
        if (period == 0) m_cnt = 0;
        else if (hit) begin m_cnt = 0; m_sel = ~m_sel; end
        else m_cnt++;
      end
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R2/R5", "sym_o", sym_o, e_sym);
    chk("R3/R6", "err_o", err_o, e_err);
    chk("R11", "sync_req_o", sync_req_o, e_sync);
    chk("R7", "lat_last_o", lat_last_o, e_lat);
    chk("R8", "lat_viol_o", lat_viol_o, e_viol);
    chk("R9", "rec_last_o", rec_last_o, e_rlast);
    chk("R9", "rec_max_o", rec_max_o, e_rmax);
  end

  task automatic summary();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  always @(negedge clk) if (rst_n) payload <= PW'($urandom);

  task automatic wait_err();
    do @(negedge clk); while (!err_o);
  endtask

  task automatic episode(int d, int r);
    wait_err();
    repeat (d) @(negedge clk);
    lock_n = 1'b1;
    repeat (r) @(negedge clk);
    lock_n = 1'b0;
    @(negedge clk);
    chk("R7", "directed latency", lat_last_o, d);
    chk("R8", "directed violation", lat_viol_o, d > 5);
    chk("R9", "directed recovery", rec_last_o, r);
  endtask

  initial begin
    int nerr;
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "reset sym_o", sym_o, {{(SW-1){1'b0}}, 1'b1});
    chk("R1", "reset err_o", err_o, 0);
    chk("R1", "reset sync_req_o", sync_req_o, 0);
    chk("R1", "reset lat", {lat_viol_o, lat_last_o}, 0);
    chk("R1", "reset rec", {rec_last_o, rec_max_o}, 0);
    rst_n = 1'b1;
    cmp_on = 1;
    // R3: default period, count flags
    nerr = 0;
    repeat (1100) begin @(negedge clk); if (err_o) nerr++; end
    chk("R3", "flags in 1100 cycles at period 200", nerr, 5);
    // R4: disabled
    period = 16'd0;
    nerr = 0;
    repeat (300) begin @(negedge clk); if (err_o) nerr++; end
    chk("R4", "flags with period 0", nerr, 0);
    // R5: short period, alternation covered by model
    period = 16'd1;
    repeat (8) @(negedge clk);
    period = 16'd3 + 16'($urandom_range(0, 5));
    repeat (200) @(negedge clk);
    // R7/R8/R9: directed episodes
    period = 16'd40;
    episode(1, 12);
    episode(5, 3);
    episode(6, 25);
    episode(3, 1);
    for (int k = 0; k < 8; k++) episode($urandom_range(1, 7), $urandom_range(1, 30));
    // latency saturation
    wait_err();
    period = 16'd0;
    repeat (300) @(negedge clk);
    lock_n = 1'b1;
    repeat (10) @(negedge clk);
    lock_n = 1'b0;
    @(negedge clk);
    chk("R7", "latency saturates", lat_last_o, 255);
    chk("R8", "saturated latency flagged", lat_viol_o, 1);
    // R10: recovery saturation
    lock_n = 1'b1;
    repeat (70000) @(negedge clk);
    lock_n = 1'b0;
    @(negedge clk);
    chk("R10", "recovery last saturates", rec_last_o, 65535);
    chk("R10", "recovery max saturates", rec_max_o, 65535);
    lock_n = 1'b1;
    repeat (20) @(negedge clk);
    lock_n = 1'b0;
    @(negedge clk);
    chk("R9", "short episode after saturation", rec_last_o, 20);
    chk("R9", "max kept", rec_max_o, 65535);
    repeat (5) @(negedge clk);
    summary();
  end
endmodule